// File: doc/BRIEF.md
# PHY Width and Alignment Adapter

This block joins a 16-bit PHY data path to a 32-bit link-layer data path on a single clock. In the receive direction it collects 16-bit halves from the PHY into 32-bit words. Each half brings two data bytes, two per-byte control flags and two per-byte error flags. The pairing is steered so that a control character always lands in byte lane 0 of the finished word. The per-byte flags of both halves are regrouped into 4-bit lane buses that travel next to the word.

In the transmit direction the block takes one 32-bit word at a time from the link layer. It presents the word to the PHY as two 16-bit halves: first bits 15:0, then bits 31:16. The single transmit control flag refers to byte 0, so it goes out only with the first half. A ready output holds off the next word until both halves have been sent. The PHY side is assumed to always accept data. The asynchronous active-low reset is released synchronously inside the block, two clocks after the input rises.

Top module: `phy_width_adapter`

## Requirements
- R1: While reset is active, rx_link_valid and tx_phy_valid are 0 and tx_link_ready is 1.
- R2: With no half pending, a valid receive half is stored. When a second valid half follows without a control flag on its lane 0, rx_link_data becomes {second, first}, so the first half fills bits 15:0. rx_link_valid is high in the cycle after the second half is sampled.
- R3: For each finished word, bit i of rx_link_ctl and rx_link_err belongs to byte lane i. Lanes 0 and 1 come from bits 0 and 1 of the first half's flags. Lanes 2 and 3 come from bits 0 and 1 of the second half's flags.
- R4: If a half is pending and the incoming half has control flag bit 0 set, the pending half is dropped and no word is produced. The incoming half becomes the new first half.
- R5: A control flag on bit 1 only (the upper byte) of an incoming second half causes no realignment, and the word is produced normally.
- R6: Cycles with rx_phy_valid low do not disturb the pairing. rx_link_valid is a single-cycle pulse, one per finished word.
- R7: A word taken when tx_link_valid and tx_link_ready are both high appears on tx_phy_data as bits 15:0 in the next cycle and as bits 31:16 in the cycle after that. tx_phy_valid is high in both cycles.
- R8: tx_phy_ctl equals the accepted tx_link_ctl during the first half and is 0 during the second half.
- R9: tx_link_ready is 0 exactly while a first half is on the PHY side, so a word offered then is not taken. It is 1 at all other times.
- R10: Reset discards a pending receive half, so the first two halves after reset form the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_phy_valid | input | 1 | Receive half is valid this cycle |
| rx_phy_data | input | 16 | Receive half, byte lane 0 in bits 7:0 |
| rx_phy_ctl | input | 2 | Per-byte control-character flags of the half |
| rx_phy_err | input | 2 | Per-byte error flags of the half |
| rx_link_valid | output | 1 | Finished receive word pulse |
| rx_link_data | output | 32 | Finished receive word |
| rx_link_ctl | output | 4 | Per-lane control flags of the word |
| rx_link_err | output | 4 | Per-lane error flags of the word |
| tx_link_valid | input | 1 | Transmit word offered |
| tx_link_ready | output | 1 | Transmit word can be taken |
| tx_link_data | input | 32 | Transmit word |
| tx_link_ctl | input | 1 | Control flag for byte lane 0 of the word |
| tx_phy_valid | output | 1 | Transmit half is valid |
| tx_phy_data | output | 16 | Transmit half |
| tx_phy_ctl | output | 1 | Control flag for the low byte of the half |

## Verification
The bench places a control flag on lane 0 of a second half after a stale half. A packer without realignment would emit a word with the control character in lane 2. The bench also places a flag on the upper byte only, where a packer that realigns too eagerly would swallow a good word. It holds the transmit valid high across several words, so a splitter that takes a word one cycle early would overwrite the pending upper half. A splitter that repeated the control flag would show it on the second half. A receive half is left pending across a reset, and a packer that kept it would pair it with the first half after reset.

// File: rtl/phy_adapt_pkg.sv
`timescale 1ns/1ps
package phy_adapt_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LOW  = 2'd1,
    TX_HIGH = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/phy_adapt_rst_sync.sv
`timescale 1ns/1ps
module phy_adapt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_n_sync = stg_q[STAGES-1];
endmodule

// File: rtl/phy_adapt_rx_pack.sv
`timescale 1ns/1ps
module phy_adapt_rx_pack #(
  parameter  int LANE_W     = 8,
  parameter  int PHY_LANES  = 2,
  localparam int HALF_W     = LANE_W * PHY_LANES,
  localparam int WORD_LANES = 2 * PHY_LANES,
  localparam int WORD_W     = LANE_W * WORD_LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [HALF_W-1:0]     in_data,
  input  logic [PHY_LANES-1:0]  in_ctl,
  input  logic [PHY_LANES-1:0]  in_err,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_data,
  output logic [WORD_LANES-1:0] out_ctl,
  output logic [WORD_LANES-1:0] out_err
);
  // pending first half
  logic                 pend_q, pend_d;
  logic [HALF_W-1:0]    low_data_q;
  logic [PHY_LANES-1:0] low_ctl_q, low_err_q;
  logic                 load_low, emit;

  // assembled word candidates
  logic [WORD_W-1:0]     word_n;
  logic [WORD_LANES-1:0] ctl_n, err_n;

  // output registers
  logic                  valid_q;
  logic [WORD_W-1:0]     data_q;
  logic [WORD_LANES-1:0] ctl_q, err_q;

  for (genvar g = 0; g < WORD_LANES; g++) begin : g_lane
    if (g < PHY_LANES) begin : g_first
      assign word_n[g*LANE_W +: LANE_W] = low_data_q[g*LANE_W +: LANE_W];
      assign ctl_n[g] = low_ctl_q[g];
      assign err_n[g] = low_err_q[g];
    end else begin : g_second
      assign word_n[g*LANE_W +: LANE_W] = in_data[(g-PHY_LANES)*LANE_W +: LANE_W];
      assign ctl_n[g] = in_ctl[g-PHY_LANES];
      assign err_n[g] = in_err[g-PHY_LANES];
    end
  end

  // A control character on lane 0 of the incoming half must start a word.
  always_comb begin
    pend_d   = pend_q;
    load_low = 1'b0;
    emit     = 1'b0;
    if (in_valid) begin
      if (!pend_q || in_ctl[0]) begin
        load_low = 1'b1;
        pend_d   = 1'b1;
      end else begin
        emit   = 1'b1;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_data_q <= '0;
      low_ctl_q  <= '0;
      low_err_q  <= '0;
    end else if (load_low) begin
      low_data_q <= in_data;
      low_ctl_q  <= in_ctl;
      low_err_q  <= in_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      err_q  <= '0;
    end else if (emit) begin
      data_q <= word_n;
      ctl_q  <= ctl_n;
      err_q  <= err_n;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_ctl   = ctl_q;
  assign out_err   = err_q;
endmodule

// File: rtl/phy_adapt_tx_split.sv
`timescale 1ns/1ps
module phy_adapt_tx_split
  import phy_adapt_pkg::*;
#(
  parameter  int LANE_W    = 8,
  parameter  int PHY_LANES = 2,
  localparam int HALF_W    = LANE_W * PHY_LANES,
  localparam int WORD_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_ctl,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_data,
  output logic              out_ctl
);
  tx_phase_e         phase_q, phase_d;
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] out_q, out_d;
  logic              ctl_q, ctl_d;
  logic              accept;

  assign in_ready = (phase_q != TX_LOW);
  assign accept   = in_valid && in_ready;

  always_comb begin
    phase_d = TX_IDLE;
    out_d   = out_q;
    ctl_d   = 1'b0;
    if (accept) begin
      phase_d = TX_LOW;
      out_d   = in_data[HALF_W-1:0];
      ctl_d   = in_ctl;
    end else if (phase_q == TX_LOW) begin
      phase_d = TX_HIGH;
      out_d   = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      out_q   <= '0;
      ctl_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      out_q   <= out_d;
      ctl_q   <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (accept) hi_q <= in_data[WORD_W-1:HALF_W];
  end

  assign out_valid = (phase_q != TX_IDLE);
  assign out_data  = out_q;
  assign out_ctl   = ctl_q;
endmodule

// File: rtl/phy_width_adapter.sv
`timescale 1ns/1ps
module phy_width_adapter #(
  parameter  int LANE_W     = 8,
  parameter  int PHY_LANES  = 2,
  localparam int HALF_W     = LANE_W * PHY_LANES,
  localparam int WORD_LANES = 2 * PHY_LANES,
  localparam int WORD_W     = LANE_W * WORD_LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_phy_valid,
  input  logic [HALF_W-1:0]     rx_phy_data,
  input  logic [PHY_LANES-1:0]  rx_phy_ctl,
  input  logic [PHY_LANES-1:0]  rx_phy_err,
  output logic                  rx_link_valid,
  output logic [WORD_W-1:0]     rx_link_data,
  output logic [WORD_LANES-1:0] rx_link_ctl,
  output logic [WORD_LANES-1:0] rx_link_err,
  input  logic                  tx_link_valid,
  output logic                  tx_link_ready,
  input  logic [WORD_W-1:0]     tx_link_data,
  input  logic                  tx_link_ctl,
  output logic                  tx_phy_valid,
  output logic [HALF_W-1:0]     tx_phy_data,
  output logic                  tx_phy_ctl
);
  logic core_rst_n;

  phy_adapt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  phy_adapt_rx_pack #(.LANE_W(LANE_W), .PHY_LANES(PHY_LANES)) u_rx (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .in_valid  (rx_phy_valid),
    .in_data   (rx_phy_data),
    .in_ctl    (rx_phy_ctl),
    .in_err    (rx_phy_err),
    .out_valid (rx_link_valid),
    .out_data  (rx_link_data),
    .out_ctl   (rx_link_ctl),
    .out_err   (rx_link_err)
  );

  phy_adapt_tx_split #(.LANE_W(LANE_W), .PHY_LANES(PHY_LANES)) u_tx (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .in_valid  (tx_link_valid),
    .in_ready  (tx_link_ready),
    .in_data   (tx_link_data),
    .in_ctl    (tx_link_ctl),
    .out_valid (tx_phy_valid),
    .out_data  (tx_phy_data),
    .out_ctl   (tx_phy_ctl)
  );
endmodule

// File: rtl/phy_width_adapter_chk.sv
`timescale 1ns/1ps
module phy_width_adapter_chk #(
  parameter  int LANE_W    = 8,
  parameter  int PHY_LANES = 2,
  localparam int HALF_W    = LANE_W * PHY_LANES,
  localparam int WORD_W    = 2 * HALF_W
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              rx_phy_valid,
  input logic [HALF_W-1:0] rx_phy_data,
  input logic              rx_phy_ctl0,
  input logic              rx_link_valid,
  input logic [WORD_W-1:0] rx_link_data,
  input logic              tx_link_valid,
  input logic              tx_link_ready,
  input logic [WORD_W-1:0] tx_link_data,
  input logic              tx_link_ctl,
  input logic              tx_phy_valid,
  input logic [HALF_W-1:0] tx_phy_data,
  input logic              tx_phy_ctl
);
  logic take;
  assign take = tx_link_valid && tx_link_ready;

  p_reset_idle_r1: assert property (@(posedge clk)
    !core_rst_n |-> (!rx_link_valid && !tx_phy_valid && tx_link_ready));

  p_rx_upper_from_last_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    rx_link_valid |-> ($past(rx_phy_valid) && rx_link_data[WORD_W-1:HALF_W] == $past(rx_phy_data)));

  p_rx_realign_no_word_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rx_phy_valid && rx_phy_ctl0) |=> !rx_link_valid);

  p_rx_single_pulse_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    rx_link_valid |=> !rx_link_valid);

  p_tx_low_first_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    take |=> (tx_phy_valid && tx_phy_data == $past(tx_link_data[HALF_W-1:0])
              && tx_phy_ctl == $past(tx_link_ctl)));

  p_tx_high_second_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    take |=> ##1 (tx_phy_valid && tx_phy_data == $past(tx_link_data[WORD_W-1:HALF_W], 2)));

  p_tx_ctl_cleared_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    take |=> ##1 !tx_phy_ctl);

  p_tx_busy_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    take |=> !tx_link_ready);
endmodule

bind phy_width_adapter phy_width_adapter_chk #(.LANE_W(LANE_W), .PHY_LANES(PHY_LANES)) u_chk (
  .clk           (clk),
  .core_rst_n    (core_rst_n),
  .rx_phy_valid  (rx_phy_valid),
  .rx_phy_data   (rx_phy_data),
  .rx_phy_ctl0   (rx_phy_ctl[0]),
  .rx_link_valid (rx_link_valid),
  .rx_link_data  (rx_link_data),
  .tx_link_valid (tx_link_valid),
  .tx_link_ready (tx_link_ready),
  .tx_link_data  (tx_link_data),
  .tx_link_ctl   (tx_link_ctl),
  .tx_phy_valid  (tx_phy_valid),
  .tx_phy_data   (tx_phy_data),
  .tx_phy_ctl    (tx_phy_ctl)
);

// File: tb/phy_width_adapter_test.sv
`timescale 1ns/1ps
module phy_width_adapter_test;
  logic        clk;
  logic        rst_n;
  logic        rx_phy_valid;
  logic [15:0] rx_phy_data;
  logic [1:0]  rx_phy_ctl, rx_phy_err;
  logic        rx_link_valid;
  logic [31:0] rx_link_data;
  logic [3:0]  rx_link_ctl, rx_link_err;
  logic        tx_link_valid, tx_link_ready, tx_link_ctl;
  logic [31:0] tx_link_data;
  logic        tx_phy_valid, tx_phy_ctl;
  logic [15:0] tx_phy_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  phy_width_adapter uut (
    .clk(clk), .rst_n(rst_n),
    .rx_phy_valid(rx_phy_valid), .rx_phy_data(rx_phy_data),
    .rx_phy_ctl(rx_phy_ctl), .rx_phy_err(rx_phy_err),
    .rx_link_valid(rx_link_valid), .rx_link_data(rx_link_data),
    .rx_link_ctl(rx_link_ctl), .rx_link_err(rx_link_err),
    .tx_link_valid(tx_link_valid), .tx_link_ready(tx_link_ready),
    .tx_link_data(tx_link_data), .tx_link_ctl(tx_link_ctl),
    .tx_phy_valid(tx_phy_valid), .tx_phy_data(tx_phy_data), .tx_phy_ctl(tx_phy_ctl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_pend;
  logic [15:0] m_low_d;
  logic [1:0]  m_low_c, m_low_e;
  bit          e_rv;
  logic [31:0] e_rw;
  logic [3:0]  e_rc, e_re;
  typedef struct { logic [15:0] d; logic c; } half_t;
  half_t       txq[$];
  bit          e_tv, e_tc, e_ready;
  logic [15:0] e_td;
  logic [31:0] last_word;
  int          words_seen = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pend = 0; e_rv = 0; e_tv = 0; e_tc = 0; e_ready = 1; txq.delete();
      check(!rx_link_valid && !tx_phy_valid && tx_link_ready, "R1 reset outputs",
            {29'd0, rx_link_valid, tx_phy_valid, tx_link_ready}, 32'd1);
    end else begin
      check(rx_link_valid == e_rv, "R6 rx valid pulse", {31'd0, rx_link_valid}, {31'd0, e_rv});
      if (e_rv) begin
        check(rx_link_data == e_rw, "R2 rx word", rx_link_data, e_rw);
        check({rx_link_ctl, rx_link_err} == {e_rc, e_re}, "R3 rx lane flags",
              {24'd0, rx_link_ctl, rx_link_err}, {24'd0, e_rc, e_re});
      end
      check(tx_phy_valid == e_tv, "R7 tx valid", {31'd0, tx_phy_valid}, {31'd0, e_tv});
      if (e_tv) check(tx_phy_data == e_td, "R7 tx half data", {16'd0, tx_phy_data}, {16'd0, e_td});
      check(tx_phy_ctl == (e_tv && e_tc), "R8 tx ctl", {31'd0, tx_phy_ctl}, {31'd0, e_tv && e_tc});
      check(tx_link_ready == e_ready, "R9 tx ready", {31'd0, tx_link_ready}, {31'd0, e_ready});
      if (rx_link_valid) begin
        last_word = rx_link_data;
        words_seen++;
      end
      // advance receive model with inputs sampled at the next edge
      e_rv = 0;
      if (rx_phy_valid) begin
        if (!m_pend || rx_phy_ctl[0]) begin
          m_pend = 1; m_low_d = rx_phy_data; m_low_c = rx_phy_ctl; m_low_e = rx_phy_err;
        end else begin
          e_rv = 1; e_rw = {rx_phy_data, m_low_d};
          e_rc = {rx_phy_ctl, m_low_c}; e_re = {rx_phy_err, m_low_e};
          m_pend = 0;
        end
      end
      // advance transmit model
      if (tx_link_valid && e_ready) begin
        txq.push_back('{d: tx_link_data[15:0],  c: tx_link_ctl});
        txq.push_back('{d: tx_link_data[31:16], c: 1'b0});
      end
      if (txq.size() > 0) begin
        half_t h;
        h = txq.pop_front();
        e_tv = 1; e_td = h.d; e_tc = h.c;
      end else begin
        e_tv = 0; e_tc = 0;
      end
      e_ready = (txq.size() == 0);
    end
  end

  // ---------------- drivers ----------------
  task automatic rx_half(input logic [15:0] d, input logic [1:0] c, input logic [1:0] e);
    @(posedge clk); #1;
    rx_phy_valid = 1; rx_phy_data = d; rx_phy_ctl = c; rx_phy_err = e;
  endtask

  task automatic rx_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_phy_valid = 0; rx_phy_ctl = 0; rx_phy_err = 0;
    end
  endtask

  // caller is at posedge+1; leaves at posedge+1 after the word is taken
  task automatic tx_put(input logic [31:0] w, input logic c, input bit last);
    tx_link_valid = 1; tx_link_data = w; tx_link_ctl = c;
    @(negedge clk);
    while (!tx_link_ready) @(negedge clk);
    @(posedge clk); #1;
    if (last) begin tx_link_valid = 0; tx_link_ctl = 0; end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 0; rx_phy_valid = 0; rx_phy_data = 0; rx_phy_ctl = 0; rx_phy_err = 0;
    tx_link_valid = 0; tx_link_data = 0; tx_link_ctl = 0;
    wait_cycles(3);
    rst_n = 1;
    wait_cycles(4);

    // R2 R3: aligned pairs, varied flags
    for (int k = 0; k < 6; k++) begin
      rx_half(16'hA000 + 16'(k), 2'(k & 1), 2'(k % 3));
      rx_half(16'h5100 + 16'(k * 7), 2'((k >> 1) & 2), 2'((k + 1) % 4));
    end
    rx_idle(2);

    // R6: gaps between and inside pairs
    rx_half(16'h1234, 2'b01, 2'b00); rx_idle(3);
    rx_half(16'h5678, 2'b00, 2'b10); rx_idle(1);
    rx_half(16'h9ABC, 2'b00, 2'b01); rx_idle(2);
    rx_half(16'hDEF0, 2'b00, 2'b00); rx_idle(3);

    // R4: control on lane 0 of a second half drops the stale half
    w0 = words_seen;
    rx_half(16'h1111, 2'b00, 2'b00);
    rx_half(16'h22BC, 2'b01, 2'b00);
    rx_half(16'h3333, 2'b00, 2'b01);
    rx_idle(3);
    check(words_seen == w0 + 1 && last_word == 32'h333322BC, "R4 realigned word",
          last_word, 32'h333322BC);

    // R5: control on upper byte only does not realign
    w0 = words_seen;
    rx_half(16'h44BC, 2'b01, 2'b00);
    rx_half(16'hBC55, 2'b10, 2'b00);
    rx_idle(3);
    check(words_seen == w0 + 1 && last_word == 32'hBC5544BC, "R5 no realign on upper byte",
          last_word, 32'hBC5544BC);

    // R7 R8 R9: single word, then a back-to-back burst with valid held high
    @(posedge clk); #1;
    tx_put(32'hCAFE_F00D, 1'b1, 1'b1);
    wait_cycles(4);
    tx_put(32'h0102_0304, 1'b1, 1'b0);
    tx_put(32'h1112_1314, 1'b0, 1'b0);
    tx_put(32'h2122_2324, 1'b1, 1'b0);
    tx_put(32'h3132_3334, 1'b0, 1'b1);
    wait_cycles(4);

    // both directions at once
    fork
      begin
        tx_put(32'hAAAA_5555, 1'b1, 1'b0);
        tx_put(32'h5555_AAAA, 1'b1, 1'b1);
      end
      begin
        rx_half(16'h0BC7, 2'b01, 2'b11);
        rx_half(16'h7E7E, 2'b00, 2'b00);
        rx_half(16'h00BC, 2'b01, 2'b00);
        rx_half(16'h9999, 2'b00, 2'b10);
        rx_idle(1);
      end
    join
    wait_cycles(4);

    // R10: reset discards a pending half
    rx_half(16'hDEAD, 2'b00, 2'b00);
    rx_idle(1);
    rst_n = 0;
    wait_cycles(2);
    rst_n = 1;
    wait_cycles(4);
    w0 = words_seen;
    rx_half(16'h6666, 2'b00, 2'b00);
    rx_half(16'h7777, 2'b00, 2'b00);
    rx_idle(3);
    check(words_seen == w0 + 1 && last_word == 32'h77776666, "R10 pending half cleared",
          last_word, 32'h77776666);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule